// File: doc/BRIEF.md
# SCSI Initiator DMA Data Bridge

This block connects a system DMA controller to the signal lines of a SCSI bus on the initiator side. It samples the target-driven control lines (busy, control/data, message, input/output and request) and the data byte through two-flop synchronizers. From these it works out the current bus phase, and it follows the request handshake by detecting rising and falling edges of REQ. In the data phase, bytes travel through a small byte queue. The bridge drives the acknowledge line by itself, so software never drives it.

The DMA side sees one data port that can be accessed 8 or 16 bits at a time. When DMA is enabled and the bus is in a data phase with REQ high, port traffic goes through the queue. Outside that condition the port reads the byte last latched from the bus and writes straight to the bus data lines. A request line asks the DMA controller for service. Its rule depends on the transfer direction and on whether the queue is empty. An interrupt pulse marks the start of a command, status or message phase. A host-controlled bus reset output is also provided, and asserting it empties the queue.

Top module: `scsi_dma_bridge`

## Requirements
- R1: The bus is in a data phase when the synchronized C/D and MSG are both 0. On a REQ rising edge in a data phase with BSY=1, I/O=1 (target to host) and DMA enabled, the synchronized data byte is appended to the queue and ACK pulses. With MSG=1 and C/D=0, a REQ rising edge neither queues a byte nor pulses ACK.
- R2: On a REQ rising edge in a data phase with BSY=1, I/O=0, DMA enabled and a non-empty queue, the oldest queued byte is removed and driven on `bus_dat_o`, and ACK pulses. If the queue is empty, nothing is removed and no ACK is produced.
- R3: On a REQ rising edge in a data phase, DRQ is set. With I/O=1 this happens when the queue is non-empty or receives a byte on that edge. With I/O=0 it happens when the queue is empty before any removal.
- R4: DRQ is cleared on every falling edge of REQ.
- R5: On a REQ rising edge with C/D=1, the queue is emptied and `irq_o` is high for exactly one clock.
- R6: `bus_rst_o` follows `host_busrst_i` one clock later. The clock in which it is asserted empties the queue. Releasing it leaves the queue contents unchanged.
- R7: A DMA-port write is queued when C/D=0, MSG=0, DMA is enabled and REQ=1, and then produces no ACK. Any other write drives the low byte of `dma_wdata_i` onto `bus_dat_o` and pulses ACK when BSY=1 and I/O=0.
- R8: A 16-bit queued write appends bits [7:0] first and bits [15:8] second. A 16-bit queued read removes two bytes and returns the first in bits [15:8] and the second in bits [7:0]. An 8-bit queued read returns the byte in bits [7:0] with zeros above.
- R9: A DMA-port read outside the queued condition returns, zero-extended, the data byte latched at the most recent REQ rising edge in any phase. It pulses ACK when BSY=1 and I/O=1.
- R10: The queue holds 8 bytes. A byte offered when it is full is dropped. A read of an empty queue returns zero and leaves it empty.
- R11: Each ACK event drives `bus_ack_o` high for exactly one clock. Bus-triggered effects appear three clocks after the bus input changes. DMA-port effects appear one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_bsy_i | input | 1 | Bus busy line, asynchronous |
| bus_cd_i | input | 1 | Bus control/data line, asynchronous |
| bus_msg_i | input | 1 | Bus message line, asynchronous |
| bus_io_i | input | 1 | Bus direction line, 1 = target to host |
| bus_req_i | input | 1 | Bus request line, asynchronous |
| bus_dat_i | input | 8 | Bus data byte from the target |
| bus_dat_o | output | 8 | Bus data byte driven toward the target |
| bus_ack_o | output | 1 | Bus acknowledge, one-clock pulse |
| bus_rst_o | output | 1 | Bus reset line |
| host_busrst_i | input | 1 | Host request to hold bus reset |
| dma_en_i | input | 1 | Enables the queued DMA path |
| dma_wr_i | input | 1 | One-clock DMA-port write strobe |
| dma_rd_i | input | 1 | One-clock DMA-port read strobe |
| dma_wide_i | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| dma_wdata_i | input | 16 | DMA write data |
| dma_rdata_o | output | 16 | DMA read data, valid one clock after the strobe |
| drq_o | output | 1 | DMA service request |
| irq_o | output | 1 | Control-phase interrupt pulse |

## Verification
The assertions assume that DMA read and write strobes are single-cycle, never overlap each other, and do not fall within a few clocks of a bus edge. Under that assumption every ACK source fires alone and the one-clock pulse property can hold. The stimulus changes the bus lines only at clock midpoints and holds each level for four clocks, which lets the synchronizers and edge detector see every transition. Each DMA access is issued in isolation, after the synchronized bus state has settled.

// File: rtl/scsi_bridge_pkg.sv
package scsi_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  // synchronized bus control lines, packed above the data byte
  typedef struct packed {
    logic bsy;
    logic cd;
    logic msg;
    logic io;
    logic req;
  } bus_ctl_t;
  localparam int CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/scsi_sync.sv
module scsi_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/scsi_byte_queue.sv
module scsi_byte_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [1:0]       push_n,
  input  logic [DW-1:0]    push_b0,
  input  logic [DW-1:0]    push_b1,
  input  logic [1:0]       pop_n,
  output logic [DW-1:0]    head0,
  output logic [DW-1:0]    head1,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W-1:0] rd_ptr1, wr_ptr1;
  logic [CNT_W-1:0] space;
  logic [1:0]       acc_push, acc_pop;

  assign rd_ptr1 = rd_ptr + PTR_W'(1);
  assign wr_ptr1 = wr_ptr + PTR_W'(1);
  assign space   = CNT_W'(DEPTH) - count;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));

  // lanes that do not fit are dropped; lanes beyond the stored bytes read nothing
  always_comb begin
    if (int'(push_n) <= int'(space)) acc_push = push_n;
    else                             acc_push = space[1:0];
    if (int'(pop_n) <= int'(count))  acc_pop  = pop_n;
    else                             acc_pop  = count[1:0];
  end

  assign head0 = (count != '0)           ? mem[rd_ptr]  : '0;
  assign head1 = (count > CNT_W'(1))     ? mem[rd_ptr1] : '0;

  // storage carries no reset; two write lanes make it a register file
  always_ff @(posedge clk) begin
    if (!flush) begin
      if (acc_push != 2'd0) mem[wr_ptr]  <= push_b0;
      if (acc_push == 2'd2) mem[wr_ptr1] <= push_b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + PTR_W'(acc_pop);
      wr_ptr <= wr_ptr + PTR_W'(acc_push);
      count  <= count + CNT_W'(acc_push) - CNT_W'(acc_pop);
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (full && push_n != 2'd0 && pop_n == 2'd0 && !flush) |=> full);
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_n != 2'd0 && push_n == 2'd0 && !flush) |=> empty);
endmodule

// File: rtl/scsi_dma_bridge.sv
module scsi_dma_bridge
  import scsi_bridge_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_bsy_i,
  input  logic        bus_cd_i,
  input  logic        bus_msg_i,
  input  logic        bus_io_i,
  input  logic        bus_req_i,
  input  logic [7:0]  bus_dat_i,
  output logic [7:0]  bus_dat_o,
  output logic        bus_ack_o,
  output logic        bus_rst_o,
  input  logic        host_busrst_i,
  input  logic        dma_en_i,
  input  logic        dma_wr_i,
  input  logic        dma_rd_i,
  input  logic        dma_wide_i,
  input  logic [15:0] dma_wdata_i,
  output logic [15:0] dma_rdata_o,
  output logic        drq_o,
  output logic        irq_o
);
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int SYNC_W = CTL_W + BYTE_W;

  bus_ctl_t          ctl_s;
  logic [BYTE_W-1:0] dat_s;
  logic              req_d;

  scsi_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_bsy_i, bus_cd_i, bus_msg_i, bus_io_i, bus_req_i, bus_dat_i}),
    .q   ({ctl_s, dat_s})
  );

  always_ff @(posedge clk) begin
    if (rst) req_d <= 1'b0;
    else     req_d <= ctl_s.req;
  end

  // edge and phase decode
  logic req_rise, req_fall, data_ph, ctrl_rise, rst_rise, flush;
  logic bus_push, bus_pop, queued;
  logic dma_q_wr, dma_q_rd, direct_wr, direct_rd, ack_set;
  logic [1:0]        push_n, pop_n;
  logic [BYTE_W-1:0] push_b0, head0, head1;
  logic [CNT_W-1:0]  q_count;
  logic              q_empty, q_full;
  logic [BYTE_W-1:0] data_reg;

  assign req_rise  = ctl_s.req & ~req_d;
  assign req_fall  = ~ctl_s.req & req_d;
  assign data_ph   = ~ctl_s.cd & ~ctl_s.msg;
  assign ctrl_rise = req_rise & ctl_s.cd;
  assign rst_rise  = host_busrst_i & ~bus_rst_o;
  assign flush     = ctrl_rise | rst_rise;

  assign bus_push = req_rise & data_ph & ctl_s.bsy &  ctl_s.io & dma_en_i;
  assign bus_pop  = req_rise & data_ph & ctl_s.bsy & ~ctl_s.io & dma_en_i & ~q_empty;

  // the bus edge owns the queue in its cycle; a coincident queued DMA access is dropped
  assign queued    = data_ph & dma_en_i & ctl_s.req;
  assign dma_q_wr  = dma_wr_i & queued & ~req_rise;
  assign dma_q_rd  = dma_rd_i & queued & ~req_rise;
  assign direct_wr = dma_wr_i & ~queued;
  assign direct_rd = dma_rd_i & ~queued;

  always_comb begin
    push_n  = 2'd0;
    push_b0 = dma_wdata_i[7:0];
    if (bus_push) begin
      push_n  = 2'd1;
      push_b0 = dat_s;
    end else if (dma_q_wr) begin
      push_n  = dma_wide_i ? 2'd2 : 2'd1;
    end
    pop_n = 2'd0;
    if (bus_pop)       pop_n = 2'd1;
    else if (dma_q_rd) pop_n = dma_wide_i ? 2'd2 : 2'd1;
  end

  scsi_byte_queue #(.DEPTH(QDEPTH), .DW(BYTE_W)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .push_n  (push_n),
    .push_b0 (push_b0),
    .push_b1 (dma_wdata_i[15:8]),
    .pop_n   (pop_n),
    .head0   (head0),
    .head1   (head1),
    .count   (q_count),
    .empty   (q_empty),
    .full    (q_full)
  );

  assign ack_set = bus_push | bus_pop
                 | (direct_wr & ctl_s.bsy & ~ctl_s.io)
                 | (direct_rd & ctl_s.bsy &  ctl_s.io);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_reg    <= '0;
      bus_dat_o   <= '0;
      bus_ack_o   <= 1'b0;
      bus_rst_o   <= 1'b0;
      dma_rdata_o <= '0;
      drq_o       <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      bus_ack_o <= ack_set;
      bus_rst_o <= host_busrst_i;
      irq_o     <= ctrl_rise;
      if (req_rise) data_reg <= dat_s;
      if (bus_pop)        bus_dat_o <= head0;
      else if (direct_wr) bus_dat_o <= dma_wdata_i[7:0];
      if (dma_q_rd)       dma_rdata_o <= dma_wide_i ? {head0, head1} : {8'h00, head0};
      else if (direct_rd) dma_rdata_o <= {8'h00, data_reg};
      if (req_fall) drq_o <= 1'b0;
      else if (req_rise && data_ph) begin
        if (ctl_s.io ? (~q_empty | bus_push) : q_empty) drq_o <= 1'b1;
      end
    end
  end

  p_ack_single_r11: assert property (@(posedge clk) disable iff (rst)
    bus_ack_o |=> !bus_ack_o);
  p_drq_drop_r4: assert property (@(posedge clk) disable iff (rst)
    req_fall |=> !drq_o);
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  p_ctrl_flush_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_rise |=> (q_count == '0));
  p_rst_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (host_busrst_i && !bus_rst_o) |=> (q_count == '0));
  p_queued_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    dma_q_wr |=> !bus_ack_o);
  p_full_flag_r10: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !q_empty);
endmodule

// File: tb/scsi_dma_bridge_tb.sv
`timescale 1ns/1ps
module scsi_dma_bridge_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_bsy_i = 0, bus_cd_i = 0, bus_msg_i = 0, bus_io_i = 0, bus_req_i = 0;
  logic [7:0]  bus_dat_i = '0;
  logic [7:0]  bus_dat_o;
  logic        bus_ack_o, bus_rst_o;
  logic        host_busrst_i = 0, dma_en_i = 0, dma_wr_i = 0, dma_rd_i = 0, dma_wide_i = 0;
  logic [15:0] dma_wdata_i = '0;
  logic [15:0] dma_rdata_o;
  logic        drq_o, irq_o;

  always #4 clk = ~clk;

  scsi_dma_bridge #(.QDEPTH(8)) u_dut (
    .clk(clk), .rst(rst),
    .bus_bsy_i(bus_bsy_i), .bus_cd_i(bus_cd_i), .bus_msg_i(bus_msg_i),
    .bus_io_i(bus_io_i), .bus_req_i(bus_req_i), .bus_dat_i(bus_dat_i),
    .bus_dat_o(bus_dat_o), .bus_ack_o(bus_ack_o), .bus_rst_o(bus_rst_o),
    .host_busrst_i(host_busrst_i), .dma_en_i(dma_en_i), .dma_wr_i(dma_wr_i),
    .dma_rd_i(dma_rd_i), .dma_wide_i(dma_wide_i), .dma_wdata_i(dma_wdata_i),
    .dma_rdata_o(dma_rdata_o), .drq_o(drq_o), .irq_o(irq_o)
  );

  int n_cmp = 0, n_bad = 0;
  int ack_cnt = 0, ack_long = 0, irq_cnt = 0;
  logic ack_prev = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ack_o) ack_cnt++;
      if (bus_ack_o && ack_prev) ack_long++;
      if (irq_o) irq_cnt++;
      ack_prev <= bus_ack_o;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic rise(input logic [7:0] d);
    bus_dat_i = d;
    bus_req_i = 1'b1;
    tick(4);
  endtask

  task automatic fall();
    bus_req_i = 1'b0;
    tick(4);
  endtask

  task automatic dwrite(input logic [15:0] w, input logic wide);
    dma_wdata_i = w;
    dma_wide_i  = wide;
    dma_wr_i    = 1'b1;
    @(negedge clk);
    dma_wr_i = 1'b0;
    #1;
  endtask

  task automatic dread(input logic wide);
    dma_wide_i = wide;
    dma_rd_i   = 1'b1;
    @(negedge clk);
    dma_rd_i = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int a0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // reset state
    chk("R11 reset ack", bus_ack_o, 0);
    chk("R3 reset drq", drq_o, 0);
    chk("R5 reset irq", irq_o, 0);
    chk("R6 reset busrst", bus_rst_o, 0);
    chk("R9 reset rdata", dma_rdata_o, 0);

    // R1 R3 R4 R10: fill the queue from the target, one beyond capacity
    dma_en_i = 1; bus_bsy_i = 1; bus_io_i = 1;
    for (int i = 0; i < 9; i++) begin
      a0 = ack_cnt;
      rise(pat(i));
      chk("R1 capture ack", ack_cnt - a0, 1);
      chk("R3 drq read dir", drq_o, 1);
      fall();
      chk("R4 drq falls", drq_o, 0);
    end
    rise(8'hEE);
    a0 = ack_cnt;
    for (int i = 0; i < 8; i++) begin
      dread(1'b0);
      chk("R10 queue order", dma_rdata_o, pat(i));
    end
    dread(1'b0);
    chk("R10 empty read zero", dma_rdata_o, 0);
    chk("R7 queued reads no ack", ack_cnt - a0, 0);

    // R1: message-only phase is not a data phase
    fall();
    bus_msg_i = 1; tick(4);
    a0 = ack_cnt;
    rise(8'h77);
    chk("R1 msg phase no ack", ack_cnt - a0, 0);
    fall();
    bus_msg_i = 0; tick(4);

    // R8: wide read ordering
    rise(8'h12);
    fall();
    rise(8'h34);
    dread(1'b1);
    chk("R8 wide read", dma_rdata_o, 16'h1234);

    // R2 R3 R7 R8: host to target
    fall();
    bus_io_i = 0; tick(4);
    a0 = ack_cnt;
    rise(8'h00);
    chk("R3 drq write empty", drq_o, 1);
    chk("R2 no pop when empty", ack_cnt - a0, 0);
    dwrite(16'hBEEF, 1'b1);
    tick(2);
    chk("R7 queued write no ack", ack_cnt - a0, 0);
    fall();
    rise(8'h00);
    chk("R2 pop low byte", bus_dat_o, 8'hEF);
    chk("R2 pop ack", ack_cnt - a0, 1);
    chk("R3 drq write nonempty", drq_o, 0);
    fall();
    rise(8'h00);
    chk("R8 pop high byte", bus_dat_o, 8'hBE);
    chk("R11 ack count", ack_cnt - a0, 2);
    fall();
    rise(8'h00);
    chk("R3 drq write drained", drq_o, 1);
    chk("R2 no pop drained", bus_dat_o, 8'hBE);

    // R5: control phase flushes and interrupts
    fall();
    bus_io_i = 1; tick(4);
    for (int i = 0; i < 3; i++) begin
      rise(pat(i + 20));
      fall();
    end
    a0 = irq_cnt;
    bus_cd_i = 1; tick(4);
    rise(8'h00);
    chk("R5 irq pulse", irq_cnt - a0, 1);
    chk("R5 irq low after", irq_o, 0);
    fall();
    bus_cd_i = 0; bus_io_i = 0; tick(4);
    rise(8'h00);
    chk("R5 flushed drq", drq_o, 1);
    dread(1'b0);
    chk("R5 flushed read", dma_rdata_o, 0);

    // R6: bus reset flushes on assertion only
    fall();
    bus_io_i = 1; tick(4);
    rise(8'h11); fall();
    rise(8'h22); fall();
    host_busrst_i = 1; tick(2);
    chk("R6 busrst high", bus_rst_o, 1);
    rise(8'h33); fall();
    host_busrst_i = 0; tick(2);
    chk("R6 busrst low", bus_rst_o, 0);
    bus_io_i = 0; tick(4);
    rise(8'h00);
    chk("R6 kept after release", bus_dat_o, 8'h33);
    fall();
    rise(8'h00);
    chk("R6 only one kept", drq_o, 1);
    fall();

    // R7 R9: direct path
    dma_en_i = 0; bus_io_i = 1; tick(4);
    a0 = ack_cnt;
    rise(8'hC3);
    chk("R1 no capture when disabled", ack_cnt - a0, 0);
    chk("R3 drq read empty", drq_o, 0);
    dread(1'b0);
    tick(2);
    chk("R9 direct read", dma_rdata_o, 16'h00C3);
    chk("R9 direct read ack", ack_cnt - a0, 1);
    dread(1'b1);
    tick(2);
    chk("R9 direct wide read", dma_rdata_o, 16'h00C3);
    dwrite(16'h7711, 1'b1);
    tick(2);
    chk("R7 direct write", bus_dat_o, 8'h11);
    chk("R7 no ack io high", ack_cnt - a0, 2);
    bus_io_i = 0; tick(4);
    dwrite(16'h4466, 1'b0);
    tick(2);
    chk("R7 direct write io low", bus_dat_o, 8'h66);
    chk("R7 direct write ack", ack_cnt - a0, 3);
    bus_bsy_i = 0; tick(4);
    dwrite(16'h0099, 1'b0);
    tick(2);
    chk("R7 no ack without bsy", ack_cnt - a0, 3);
    fall();
    bus_bsy_i = 1; dma_en_i = 1; tick(4);
    dwrite(16'h002B, 1'b0);
    tick(2);
    chk("R7 req low goes direct", bus_dat_o, 8'h2B);
    chk("R7 req low ack", ack_cnt - a0, 4);
    rise(8'h00);
    chk("R7 direct not queued", drq_o, 1);
    fall();

    chk("R11 ack single clock", ack_long, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule